// File: doc/BRIEF.md
# Transmit Clock and Receive Activity Alarm

This block guards a line interface against two silent failures. It watches the transmit clock supplied by the terminal side for a level that stops changing, and it watches the recovered receive rails for a long run with no marks. Each condition drives its own active-low alarm line. Both monitors count cycles of a free-running reference clock, which also acts as the receive bit clock, so a zero run is measured in bit periods.

The transmit clock runs in a foreign domain. It is brought into the reference domain through a synchroniser, and every level change it shows there restarts a run counter. The receive rails are taken to be already aligned to the reference clock, with one bit per cycle. A mark on either rail restarts the second run counter. Each counter stops at a fixed limit of 24 cycles, and its alarm stays asserted while the counter is held there. The first activity afterwards clears the alarm, with no recovery delay.

Top module: `line_alarm_monitor`

## Requirements
- R1: After a synchronous reset both alarm outputs are high (inactive).
- R2: If the transmit clock input stays at one level, high or low, `txclk_dead_n` is still high 19 reference cycles after the last change and is low 32 reference cycles after it.
- R3: Once `txclk_dead_n` is low, one change of the transmit clock level brings it back high within 4 reference cycles.
- R4: A transmit clock that holds each level for at least 2 reference cycles keeps `txclk_dead_n` high all the time.
- R5: With both receive rails sampled low for 23 cycles in a row after the last mark, `rxsig_dead_n` is still high. After the 24th such cycle it goes low.
- R6: A mark on the positive rail alone, or on the negative rail alone, returns `rxsig_dead_n` high in the cycle after the mark is sampled and restarts the zero run.
- R7: During an unbroken zero run or stuck clock, the alarm stays low for as long as the condition lasts, with no wrap-around, even after many times the limit.
- R8: The two monitors are independent. Receive rail activity has no effect on `txclk_dead_n`, and transmit clock activity has no effect on `rxsig_dead_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock, also the receive bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_clk_mon | input | 1 | Transmit clock under observation, asynchronous to clk_ref |
| rx_pos | input | 1 | Positive receive rail, one bit per clk_ref cycle |
| rx_neg | input | 1 | Negative receive rail, one bit per clk_ref cycle |
| txclk_dead_n | output | 1 | Low while the transmit clock is judged stuck |
| rxsig_dead_n | output | 1 | Low while the receive rails show a long zero run |

## Verification
The assertions assume that the receive rails are stable around each clk_ref edge and carry one bit per cycle. They also assume that a transmit clock counted as alive holds each level for at least two reference cycles, so the synchroniser cannot miss a transition. The stimulus changes every input shortly after a rising reference edge and never inside the setup window. It gives the transmit clock half-periods of three reference cycles. The stuck-clock window checks (R2) sample at its bounds, and never at an exact count, because the synchroniser delay belongs to the design and the bench does not model it.

// File: rtl/line_alarm_pkg.sv
// Shared constants for the line alarm monitor.
// Assumes: the run limit fits well inside the permitted 20..32 window.
package line_alarm_pkg;
    localparam int unsigned LA_SYNC_DEPTH = 2;
    localparam int unsigned LA_RUN_LIMIT  = 24;
endpackage

// File: rtl/level_sync.sv
// Multi-flop synchroniser for a single asynchronous level.
// Assumes: the input holds each level long enough to be seen (>= 2 clocks).
module level_sync #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [DEPTH-1:0] stage;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            // Capture the raw asynchronous level.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[0] <= 1'b0;
                else        stage[0] <= d_async;
            end
        end else begin : g_next
            // Let metastability settle through one more flop.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[i] <= 1'b0;
                else        stage[i] <= stage[i-1];
            end
        end
    end

    assign q_sync = stage[DEPTH-1];
endmodule

// File: rtl/toggle_detect.sv
// Flags any change of a synchronised level relative to the previous cycle.
// Assumes: the input is already in the clk domain.
module toggle_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic changed
);
    logic level_q;

    // Remember the level seen last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign changed = level ^ level_q;
endmodule

// File: rtl/activity_timer.sv
// Counts cycles without activity and saturates at LIMIT; alarm low at limit.
// Assumes: activity is synchronous to clk; LIMIT >= 2.
module activity_timer #(
    parameter int unsigned LIMIT = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic activity,
    output logic alarm_n
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM_V  = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] LIM_M1 = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] run_cnt;

    // Restart on activity, otherwise count up to the limit and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)                run_cnt <= '0;
        else if (activity)         run_cnt <= '0;
        else if (run_cnt != LIM_V) run_cnt <= run_cnt + 1'b1;
    end

    assign alarm_n = (run_cnt != LIM_V);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= LIM_V) else $error("run counter past limit"); // R7
    AST_ACTIVITY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> alarm_n) else $error("alarm not cleared"); // R6
    AST_ALARM_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!activity && run_cnt == LIM_M1) |=> !alarm_n) else $error("alarm late"); // R5
    AST_ALARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_n && !activity) |=> !alarm_n) else $error("alarm dropped"); // R7
endmodule

// File: rtl/line_alarm_monitor.sv
// Top: stuck transmit clock alarm and receive zero-run alarm, both active low.
// Assumes: rails are aligned to clk_ref, one bit per cycle; tx clock is async.
module line_alarm_monitor
    import line_alarm_pkg::*;
#(
    parameter int unsigned SYNC_DEPTH = LA_SYNC_DEPTH,
    parameter int unsigned RUN_LIMIT  = LA_RUN_LIMIT
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic tx_clk_mon,
    input  logic rx_pos,
    input  logic rx_neg,
    output logic txclk_dead_n,
    output logic rxsig_dead_n
);
    logic txclk_sync;
    logic txclk_edge;
    logic rx_mark;

    level_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk(clk_ref), .rst_n(rst_n), .d_async(tx_clk_mon), .q_sync(txclk_sync)
    );

    toggle_detect u_edge (
        .clk(clk_ref), .rst_n(rst_n), .level(txclk_sync), .changed(txclk_edge)
    );

    activity_timer #(.LIMIT(RUN_LIMIT)) u_clk_timer (
        .clk(clk_ref), .rst_n(rst_n), .activity(txclk_edge), .alarm_n(txclk_dead_n)
    );

    assign rx_mark = rx_pos | rx_neg;

    activity_timer #(.LIMIT(RUN_LIMIT)) u_sig_timer (
        .clk(clk_ref), .rst_n(rst_n), .activity(rx_mark), .alarm_n(rxsig_dead_n)
    );

    AST_MARK_CLEARS_LOS: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (rx_pos || rx_neg) |=> rxsig_dead_n) else $error("mark ignored"); // R6
    AST_SYNC_EDGE_CLEARS: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (txclk_sync != $past(txclk_sync)) |=> txclk_dead_n) else $error("edge ignored"); // R3
endmodule

// File: tb/tb_line_alarm_monitor.sv
module tb_line_alarm_monitor;
    localparam int CLK_P = 10;

    typedef struct {
        int    due;
        bit    is_clk;
        bit    exp;
        string tag;
    } exp_t;

    logic clk_ref = 1'b0;
    logic rst_n = 1'b0;
    logic tx_clk_mon = 1'b0;
    logic rx_pos = 1'b0;
    logic rx_neg = 1'b0;
    logic txclk_dead_n, rxsig_dead_n;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    exp_t sb[$];

    line_alarm_monitor dut (
        .clk_ref(clk_ref), .rst_n(rst_n), .tx_clk_mon(tx_clk_mon),
        .rx_pos(rx_pos), .rx_neg(rx_neg),
        .txclk_dead_n(txclk_dead_n), .rxsig_dead_n(rxsig_dead_n)
    );

    always #(CLK_P/2) clk_ref = ~clk_ref;
    always @(posedge clk_ref) cyc <= cyc + 1;

    // Advance n cycles, returning just after the rising edge.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk_ref);
            #1;
        end
    endtask

    // Driver side: queue an expectation for this cycle's falling edge.
    task automatic expect_out(input bit is_clk, input bit val, input string tag);
        exp_t e;
        e.due = cyc; e.is_clk = is_clk; e.exp = val; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: pop and compare every expectation due this cycle.
    always @(negedge clk_ref) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            logic act;
            e = sb.pop_front();
            act = e.is_clk ? txclk_dead_n : rxsig_dead_n;
            n_chk++;
            if (act !== e.exp) begin
                n_fail++;
                $display("FAIL %s: %s actual=%b expected=%b", e.tag,
                         e.is_clk ? "txclk_dead_n" : "rxsig_dead_n", act, e.exp);
            end
        end
    end

    // Toggle the tx clock every 3 cycles for n half-periods, checking R4.
    task automatic run_txclk(input int halves, input string tag);
        for (int i = 0; i < halves; i++) begin
            tx_clk_mon = ~tx_clk_mon;
            step(3);
            expect_out(1'b1, 1'b1, tag);
        end
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        expect_out(1'b1, 1'b1, "R1");
        expect_out(1'b0, 1'b1, "R1");

        // R4 and R8: clock alive; rails silent long enough for LOS.
        run_txclk(12, "R4");
        expect_out(1'b0, 1'b0, "R8 rails silent");
        run_txclk(8, "R8 clk alive during LOS");

        // R5: a mark, then exactly 23 then 24 zero cycles.
        rx_pos = 1'b1;
        step(1);
        expect_out(1'b0, 1'b1, "R6 pos rail");
        rx_pos = 1'b0;
        step(23);
        expect_out(1'b0, 1'b1, "R5 23 zeros");
        step(1);
        expect_out(1'b0, 1'b0, "R5 24 zeros");

        // R6: negative rail alone.
        rx_neg = 1'b1;
        step(1);
        expect_out(1'b0, 1'b1, "R6 neg rail");
        rx_neg = 1'b0;
        step(23);
        expect_out(1'b0, 1'b1, "R6 restart");
        step(1);
        expect_out(1'b0, 1'b0, "R6 restart");

        // R2: clock stuck at its current level (high after even count? toggle to high).
        tx_clk_mon = 1'b1;
        step(19);
        expect_out(1'b1, 1'b1, "R2 stuck high early");
        step(13);
        expect_out(1'b1, 1'b0, "R2 stuck high late");
        // R8: rail marks during LOC do not clear it.
        for (int i = 0; i < 10; i++) begin
            rx_pos = 1'b1; step(1); rx_pos = 1'b0; step(1);
        end
        expect_out(1'b1, 1'b0, "R8 marks vs LOC");
        // R7: long stuck period.
        step(100);
        expect_out(1'b1, 1'b0, "R7 clock held");

        // R3: recovery, then stuck low.
        tx_clk_mon = 1'b0;
        step(4);
        expect_out(1'b1, 1'b1, "R3 recovery");
        step(15);
        expect_out(1'b1, 1'b1, "R2 stuck low early");
        step(13);
        expect_out(1'b1, 1'b0, "R2 stuck low late");

        // R7: long zero run; then R3 again with rails quiet.
        step(150);
        expect_out(1'b0, 1'b0, "R7 zero run");
        tx_clk_mon = 1'b1;
        step(4);
        expect_out(1'b1, 1'b1, "R3 recovery 2");
        expect_out(1'b0, 1'b0, "R8 clk vs LOS");

        step(2);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule